// File: doc/BRIEF.md
# Clock and Buzzer Tone Output Divider

This block drives a clock or buzzer tone on a set of output pins, one pin per channel. Each channel has its own control register. The register holds three fields: an output-enable bit, a bit that picks the source, and a 3-bit divider code. The source is either the main clock or a slow secondary clock. Both channels share one free-running prescaler. Each channel picks one prescaler tap and gates it onto its pin.

The secondary clock is sampled into the main clock domain through a synchroniser. Its rising edges then step a second prescaler, so all logic runs on the main clock and no clock mux is needed. A change to the enable takes effect only at a falling edge of the selected divided clock. Output therefore starts and stops only on whole cycles of that clock, and the pin never shows a shortened high or low phase. The source and divider fields are copied into the live datapath only while the channel is idle. Software writes them with the enable clear, then sets the enable in a later write.

Top module: `clkbuz_out`

## Requirements
- R1: After reset:
  - every control register reads back as 0, which means disabled, main source and divider code 0;
  - every output pin is low.
- R2: The register readback returns the last value written to that channel, with this layout:
  - bit 7 is the enable;
  - bit 3 is the source (0 = main clock, 1 = secondary clock);
  - bits 2:0 are the divider code;
  - bits 6:4 always read 0.
- R3: With the main source and divider code k, every high phase and every low phase between pulses lasts exactly 2^k main clock cycles.
- R4: With the secondary source and divider code k, every high and low phase lasts exactly 2^k secondary clock periods.
- R5: After the enable is set, the first rising edge on the pin appears within two output periods plus 4 main clock cycles.
- R6: No truncated phase appears. The first pulse after enabling has full width, and so does the last pulse after disabling.
- R7: After the enable is cleared at the end of a pulse, at most one further full pulse is emitted.
- R8: While the channel is disabled and idle, the pin stays low.
- R9: The source and divider fields do not take effect while the channel is running. A new divider code written with the enable still set changes the frequency only after the channel has been disabled and enabled again.
- R10: Each channel responds only to writes addressed to it. While one channel runs, the other channel's pin stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| sub_clk | input | 1 | Slow secondary clock, sampled in the main clock domain |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | CHAN_W (1) | Channel addressed by the write |
| wr_data | input | 8 | Value to write into the control register |
| rd_data | output | NUM_CH*8 (16) | Readback of all control registers; channel n occupies bits n*8+7:n*8 |
| buz_out | output | NUM_CH (2) | Clock/buzzer output, one bit per channel |

## Verification
A disable request can land in the same cycle in which the gate samples the enable at a divided-clock falling edge.

The bench provokes this by clearing the enable at the first sample after each measured pulse ends, on every source and divider code of both channels. It judges the result at the pin: at most one further pulse may follow, that pulse must have full width, and the pin must then stay low.

A second overlap is a divider rewrite while the channel runs. Here the bench requires the old frequency to persist until a disable/enable cycle.

// File: rtl/clkbuz_pkg.sv
package clkbuz_pkg;
  localparam int CODE_W  = 3;
  localparam int STAGES  = 1 << CODE_W;
  localparam int REG_W   = 8;
  localparam int EN_POS  = 7;
  localparam int SRC_POS = 3;

  typedef struct packed {
    logic              en;
    logic              src;
    logic [CODE_W-1:0] code;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] d);
    ctrl_t c;
    c.en   = d[EN_POS];
    c.src  = d[SRC_POS];
    c.code = d[CODE_W-1:0];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
    logic [REG_W-1:0] r;
    r              = '0;
    r[EN_POS]      = c.en;
    r[SRC_POS]     = c.src;
    r[CODE_W-1:0]  = c.code;
    return r;
  endfunction
endpackage

// File: rtl/clkbuz_prescaler.sv
module clkbuz_prescaler #(
  parameter int STAGES = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sub_clk,
  output logic [STAGES-1:0] main_cnt,
  output logic [STAGES-1:0] sub_cnt
);
  logic [SYNC_N:0] sync_q;
  logic            sub_rise;

  assign sub_rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '0;
      main_cnt <= '0;
      sub_cnt  <= '0;
    end else begin
      sync_q   <= {sync_q[SYNC_N-1:0], sub_clk};
      main_cnt <= main_cnt + 1'b1;
      if (sub_rise) sub_cnt <= sub_cnt + 1'b1;
    end
  end

  // R4: the secondary prescaler advances by at most one step per main cycle
  p_sub_single_step_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sub_cnt) |-> sub_cnt == STAGES'($past(sub_cnt) + 1'b1));
endmodule

// File: rtl/clkbuz_ctrlreg.sv
module clkbuz_ctrlreg
  import clkbuz_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int CHAN_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic [REG_W-1:0]  wr_data,
  output ctrl_t             ctrl,
  output logic [REG_W-1:0]  rd_data
);
  logic wr_hit;
  assign wr_hit = wr_en && (wr_chan == CHAN_W'(IDX));

  always_ff @(posedge clk) begin
    if (rst)         ctrl <= '0;
    else if (wr_hit) ctrl <= unpack_ctrl(wr_data);
  end

  assign rd_data = pack_ctrl(ctrl);

  // R2: readback after a write returns the written fields, unused bits zero
  p_readback_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_hit) && !$past(rst)) |->
      (rd_data[REG_W-1] == $past(wr_data[REG_W-1]) &&
       rd_data[SRC_POS:0] == $past(wr_data[SRC_POS:0]) &&
       rd_data[REG_W-2:SRC_POS+1] == '0));

  // R10: a write to another channel leaves this register unchanged
  p_other_write_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(wr_chan) != CHAN_W'(IDX) && !$past(rst)) |-> $stable(rd_data));
endmodule

// File: rtl/clkbuz_gate.sv
module clkbuz_gate
  import clkbuz_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [STAGES-1:0] main_cnt,
  input  logic [STAGES-1:0] sub_cnt,
  output logic              pin
);
  logic              act_src;
  logic [CODE_W-1:0] act_code;
  logic              div, div_prev_q, div_fall;
  logic              gate_q, gate_n;

  assign div      = act_src ? sub_cnt[act_code] : main_cnt[act_code];
  assign div_fall = div_prev_q & ~div;
  assign gate_n   = div_fall ? ctrl.en : gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_src    <= 1'b0;
      act_code   <= '0;
      div_prev_q <= 1'b0;
      gate_q     <= 1'b0;
      pin        <= 1'b0;
    end else begin
      if (!gate_q && !ctrl.en) begin
        act_src  <= ctrl.src;
        act_code <= ctrl.code;
      end
      div_prev_q <= div;
      gate_q     <= gate_n;
      pin        <= div & gate_n;
    end
  end

  // R6: the gate only moves while the divided clock is low
  p_gate_in_low_phase_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(gate_q) |-> !div_prev_q);

  // R9: live source and divider stay frozen while the gate is open
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    gate_q |-> ($stable(act_code) && $stable(act_src)));

  // R8: a closed gate keeps the pin low
  p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
    !gate_q |-> !pin);

  // R5: a pulse can only begin with the gate open
  p_rise_needs_gate_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(pin) |-> gate_q);
endmodule

// File: rtl/clkbuz_out.sv
module clkbuz_out
  import clkbuz_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int SYNC_N = 2,
  localparam int CHAN_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sub_clk,
  input  logic                    wr_en,
  input  logic [CHAN_W-1:0]       wr_chan,
  input  logic [REG_W-1:0]        wr_data,
  output logic [NUM_CH*REG_W-1:0] rd_data,
  output logic [NUM_CH-1:0]       buz_out
);
  logic [STAGES-1:0] main_cnt, sub_cnt;

  clkbuz_prescaler #(.STAGES(STAGES), .SYNC_N(SYNC_N)) u_pre (
    .clk(clk), .rst(rst), .sub_clk(sub_clk),
    .main_cnt(main_cnt), .sub_cnt(sub_cnt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ctrl_t ctrl;

    clkbuz_ctrlreg #(.IDX(g), .CHAN_W(CHAN_W)) u_reg (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan),
      .wr_data(wr_data), .ctrl(ctrl),
      .rd_data(rd_data[g*REG_W +: REG_W])
    );

    clkbuz_gate u_gate (
      .clk(clk), .rst(rst), .ctrl(ctrl),
      .main_cnt(main_cnt), .sub_cnt(sub_cnt), .pin(buz_out[g])
    );
  end
endmodule

// File: tb/clkbuz_out_test.sv
module clkbuz_out_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sub_clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_chan = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] rd_data;
  logic [1:0]  buz_out;

  int checks = 0, errors = 0, bad_other = 0, oth = 1, wd = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // secondary clock: 6 main cycles per period
  int sdiv = 0;
  always @(negedge clk) begin
    if (sdiv == 2) begin sdiv <= 0; sub_clk <= ~sub_clk; end
    else sdiv <= sdiv + 1;
  end

  clkbuz_out uut (
    .clk(clk), .rst(rst), .sub_clk(sub_clk), .wr_en(wr_en),
    .wr_chan(wr_chan), .wr_data(wr_data), .rd_data(rd_data), .buz_out(buz_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (buz_out[oth]) bad_other++;
  endtask

  task automatic wr(input int ch, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = 1'(ch); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int ch, input bit lvl, input int cap, output int n);
    n = 1;
    step();
    while (buz_out[ch] == lvl && n < cap) begin n++; step(); end
  endtask

  task automatic run_cfg(input int ch, input bit src, input int k);
    int half, per, lat, n, pulses, run, quiet;
    half = (1 << k) * (src ? 6 : 1);
    per  = 2 * half;
    oth  = 1 - ch;
    wr(ch, {1'b0, 3'b000, src, 3'(k)});
    repeat (4) step();
    bad_other = 0;
    wr(ch, {1'b1, 3'b000, src, 3'(k)});
    lat = 0;
    while (!buz_out[ch] && lat < 2 * per + 8) begin step(); lat++; end
    check(buz_out[ch] && lat <= 2 * per + 4, "R5", "start latency", lat, 2 * per + 4);
    for (int i = 0; i < 3; i++) begin
      measure(ch, 1'b1, 2 * per, n);
      check(n == half, (i == 0) ? "R6" : (src ? "R4" : "R3"), "high width", n, half);
      if (i < 2) begin
        measure(ch, 1'b0, 2 * per, n);
        check(n == half, src ? "R4" : "R3", "low width", n, half);
      end
    end
    // disable right after a pulse ends
    wr_en = 1'b1; wr_chan = 1'(ch); wr_data = {1'b0, 3'b000, src, 3'(k)};
    step();
    wr_en = 1'b0;
    pulses = 0; run = 0;
    for (int t = 0; t < 3 * per + 8; t++) begin
      step();
      if (buz_out[ch]) run++;
      else if (run > 0) begin
        pulses++;
        check(run == half, "R6", "last pulse width", run, half);
        run = 0;
      end
    end
    check(pulses <= 1 && run == 0, "R7", "pulses after disable", pulses, 1);
    quiet = 0;
    for (int t = 0; t < 2 * per; t++) begin step(); if (buz_out[ch]) quiet++; end
    check(quiet == 0, "R8", "high samples while disabled", quiet, 0);
    check(bad_other == 0, "R10", "other channel high samples", bad_other, 0);
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 190000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, hi;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    hi = 0;
    for (int t = 0; t < 40; t++) begin @(negedge clk); if (buz_out != 2'b00) hi++; end
    check(rd_data == 16'h0000, "R1", "readback after reset", rd_data, 0);
    check(hi == 0, "R1", "pin high after reset", hi, 0);

    // R2: readback layout, bits 6:4 read zero
    wr(0, 8'h7D);
    check(rd_data[7:0] == 8'h0D, "R2", "ch0 readback", rd_data[7:0], 8'h0D);
    check(rd_data[15:8] == 8'h00, "R10", "ch1 untouched", rd_data[15:8], 0);
    wr(1, 8'hF6);
    check(rd_data[15:8] == 8'h86, "R2", "ch1 readback", rd_data[15:8], 8'h86);
    check(rd_data[7:0] == 8'h0D, "R10", "ch0 untouched", rd_data[7:0], 8'h0D);
    wr(1, 8'h00);
    wr(0, 8'h00);
    repeat (20) @(negedge clk);

    // sweep every source and divider code on both channels
    for (int ch = 0; ch < 2; ch++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 8; k++)
          run_cfg(ch, s[0], k);

    // R9: divider rewrite while running keeps the old rate
    oth = 1;
    wr(0, 8'h01);
    repeat (4) @(negedge clk);
    wr(0, 8'h81);
    n = 0;
    while (!buz_out[0] && n < 20) begin @(negedge clk); n++; end
    wr(0, 8'h83);
    check(rd_data[7:0] == 8'h83, "R2", "readback of rewrite", rd_data[7:0], 8'h83);
    n = 0;
    while (buz_out[0] && n < 20) begin @(negedge clk); n++; end
    n = 0;
    while (!buz_out[0] && n < 20) begin @(negedge clk); n++; end
    measure(0, 1'b1, 40, n);
    check(n == 2, "R9", "width after running rewrite", n, 2);
    wr(0, 8'h03);
    repeat (40) @(negedge clk);
    wr(0, 8'h83);
    n = 0;
    while (!buz_out[0] && n < 60) begin @(negedge clk); n++; end
    measure(0, 1'b1, 60, n);
    check(n == 8, "R9", "width after re-enable", n, 8);
    wr(0, 8'h00);
    repeat (60) @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule